// File: doc/BRIEF.md
# Virtual-8086 Interrupt Redirection Lookup

This block chooses the dispatch path for a software interrupt raised while the processor runs a virtual-8086 task. It is started with the 8-bit vector, the base and limit of the current task state segment, and a flag that says whether the virtual-mode extensions are on. When the extensions are on, it reads the 16-bit I/O bitmap offset word from the task state segment through a byte-wide memory port. It then reads the single byte of the 256-bit redirection map that holds this vector's bit. That map is 32 bytes long and ends just below the I/O bitmap.

The block reports one of three outcomes. The first is an ordinary protected-mode dispatch through the interrupt descriptor table. The second is a real-mode style dispatch through a fixed vector table at linear address 0, whose limit and access-rights byte the block supplies. The third is a general-protection fault with a zero error code. The fixed table values go only to the result port and so never reach the programmed descriptor-table register. Stack pushes, descriptor reads and privilege or virtual-flag logic belong to the blocks that consume the result.

Top module: `v86_redirect_lookup`

## Requirements
- R1: After reset, `done` and `mem_req` are low and the result outputs (`disp_kind`, `tbl_base`, `tbl_limit`, `tbl_ar`) are all zero.
- R2: When `ext_en` is low at the accepted `start`, the block makes no memory request and reports protected-mode dispatch (`disp_kind` = 1), with `done` high in the cycle after `start`.
- R3: When `ext_en` is high and `tss_limit` is below 103, the block makes no memory request and reports a fault (`disp_kind` = 3), with `done` high in the cycle after `start`.
- R4: Otherwise the block first reads the offset low byte at `tss_base`+102, then the high byte at `tss_base`+103. Each request keeps `mem_req` high with a stable `mem_addr` until a cycle with `mem_rdy` high.
- R5: The map byte is read at `tss_base` + offset − 32 + vector[7:3], with all sums modulo 2^32. The vector's bit within that byte is vector[2:0], counted from bit 0.
- R6: When offset − 32 + vector[7:3] (modulo 2^32) exceeds `tss_limit`, the block reports a fault after the two offset reads and does not read the map.
- R7: A clear map bit gives real-mode dispatch (`disp_kind` = 2) with `tbl_base` = 0, `tbl_limit` = 0x3FF and `tbl_ar` = 0x92.
- R8: A set map bit gives protected-mode dispatch. For any result other than real-mode dispatch, `tbl_base`, `tbl_limit` and `tbl_ar` are zero.
- R9: `done` is high for exactly one cycle per lookup. The result stays unchanged until the next accepted `start`, and a `start` during a lookup is ignored.
- R10: When the offset is placed fewer than 32 bytes past the offset field, map bytes come from whatever lies at the computed address. This includes the offset field's own high byte, which serves vectors 0 to 7 when the offset is 135.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a lookup when the block is idle |
| ext_en | input | 1 | Virtual-mode extensions enabled |
| vector | input | 8 | Interrupt vector |
| tss_base | input | 32 | Linear base of the task state segment |
| tss_limit | input | 32 | Limit of the task state segment |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 32 | Byte read address |
| mem_rdy | input | 1 | Read data valid; completes the request |
| mem_rdata | input | 8 | Read data |
| done | output | 1 | One-cycle completion pulse |
| disp_kind | output | 2 | 0 none, 1 protected-mode, 2 real-mode style, 3 fault |
| tbl_base | output | 32 | Vector table base for real-mode style dispatch |
| tbl_limit | output | 16 | Vector table limit for real-mode style dispatch |
| tbl_ar | output | 8 | Vector table access rights for real-mode style dispatch |

## Verification
The assertions check several properties on every cycle. A waiting request holds its address. `done` never lasts two cycles. The result does not move while the block idles. A disabled extension or a too-small segment limit never reaches memory and ends in the right outcome. A map read is only issued at an offset inside the limit. Whether the right byte and bit decided the outcome can only be shown by the bench. It sweeps all 256 vectors over several offset and limit layouts: limit and wrap boundaries, the offset field overlapping the map, and random memory latency. It also checks the recorded request addresses and a start pulse given mid-lookup.

// File: rtl/v86rl_pkg.sv
package v86rl_pkg;

    localparam int unsigned ADDR_W    = 32;
    localparam int unsigned OFS_W     = 16;
    localparam int unsigned DATA_W    = 8;
    localparam int unsigned VEC_W     = 8;
    localparam int unsigned BIT_SEL_W = 3;
    localparam int unsigned LIM_W     = 16;
    localparam int unsigned AR_W      = 8;

    // Task state segment layout facts the lookup depends on
    localparam logic [ADDR_W-1:0] OFS_FIELD_LO  = ADDR_W'(102);
    localparam logic [ADDR_W-1:0] OFS_FIELD_HI  = ADDR_W'(103);
    localparam logic [ADDR_W-1:0] MIN_TSS_LIMIT = ADDR_W'(103);
    localparam logic [ADDR_W-1:0] MAP_BYTES     = ADDR_W'((1 << VEC_W) >> BIT_SEL_W);

    // Fixed real-mode vector table
    localparam logic [ADDR_W-1:0] RM_BASE  = '0;
    localparam logic [LIM_W-1:0]  RM_LIMIT = LIM_W'(((1 << VEC_W) * 4) - 1);
    localparam logic [AR_W-1:0]   RM_AR    = 8'h92;

    typedef enum logic [1:0] {
        DISP_NONE  = 2'd0,
        DISP_PMODE = 2'd1,
        DISP_REAL  = 2'd2,
        DISP_FAULT = 2'd3
    } disp_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RD_LO = 3'd1,
        ST_RD_HI = 3'd2,
        ST_RD_BM = 3'd3,
        ST_DONE  = 3'd4
    } state_e;

    typedef struct packed {
        disp_e             kind;
        logic [ADDR_W-1:0] base;
        logic [LIM_W-1:0]  limit;
        logic [AR_W-1:0]   ar;
    } disp_t;

    // Offset of the map byte relative to the segment base (wraps modulo 2^ADDR_W)
    function automatic logic [ADDR_W-1:0] map_byte_ofs(input logic [OFS_W-1:0] ofs,
                                                       input logic [VEC_W-1:0] vec);
        logic [ADDR_W-1:0] wide_ofs;
        logic [ADDR_W-1:0] byte_idx;
        wide_ofs = ADDR_W'(ofs);
        byte_idx = ADDR_W'(vec >> BIT_SEL_W);
        return wide_ofs - MAP_BYTES + byte_idx;
    endfunction

    function automatic disp_t make_disp(input disp_e kind);
        disp_t d;
        d.kind  = kind;
        d.base  = '0;
        d.limit = '0;
        d.ar    = '0;
        if (kind == DISP_REAL) begin
            d.base  = RM_BASE;
            d.limit = RM_LIMIT;
            d.ar    = RM_AR;
        end
        return d;
    endfunction

endpackage

// File: rtl/v86rl_addr_gen.sv
module v86rl_addr_gen
    import v86rl_pkg::*;
(
    input  state_e              state,
    input  logic [ADDR_W-1:0]   base_q,
    input  logic [ADDR_W-1:0]   limit_q,
    input  logic [VEC_W-1:0]    vec_q,
    input  logic [DATA_W-1:0]   ofs_lo_q,
    input  logic [DATA_W-1:0]   ofs_hi,
    input  logic [ADDR_W-1:0]   map_ofs_q,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [ADDR_W-1:0]   map_ofs_next,
    output logic                map_over_limit
);

    always_comb begin
        map_ofs_next   = map_byte_ofs({ofs_hi, ofs_lo_q}, vec_q);
        map_over_limit = (map_ofs_next > limit_q);
    end

    always_comb begin
        case (state)
            ST_RD_LO: mem_addr = base_q + OFS_FIELD_LO;
            ST_RD_HI: mem_addr = base_q + OFS_FIELD_HI;
            ST_RD_BM: mem_addr = base_q + map_ofs_q;
            default:  mem_addr = '0;
        endcase
    end

endmodule

// File: rtl/v86rl_ctrl.sv
module v86rl_ctrl
    import v86rl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                ext_en,
    input  logic [VEC_W-1:0]    vector,
    input  logic [ADDR_W-1:0]   tss_base,
    input  logic [ADDR_W-1:0]   tss_limit,
    input  logic                mem_rdy,
    input  logic [DATA_W-1:0]   mem_rdata,
    input  logic [ADDR_W-1:0]   map_ofs_next,
    input  logic                map_over_limit,
    output state_e              state,
    output logic                mem_req,
    output logic                done,
    output logic [VEC_W-1:0]    vec_q,
    output logic [ADDR_W-1:0]   base_q,
    output logic [ADDR_W-1:0]   limit_q,
    output logic [ADDR_W-1:0]   map_ofs_q,
    output logic [DATA_W-1:0]   ofs_lo_q,
    output logic                decide,
    output disp_e               decide_kind
);

    state_e state_n;
    logic   accept;
    logic   map_bit;

    assign accept  = (state == ST_IDLE) && start;
    assign map_bit = mem_rdata[vec_q[BIT_SEL_W-1:0]];

    always_comb begin
        state_n     = state;
        decide      = 1'b0;
        decide_kind = DISP_NONE;
        case (state)
            ST_IDLE: begin
                if (start) begin
                    if (!ext_en) begin
                        decide      = 1'b1;
                        decide_kind = DISP_PMODE;
                        state_n     = ST_DONE;
                    end else if (tss_limit < MIN_TSS_LIMIT) begin
                        decide      = 1'b1;
                        decide_kind = DISP_FAULT;
                        state_n     = ST_DONE;
                    end else begin
                        state_n     = ST_RD_LO;
                    end
                end
            end
            ST_RD_LO: begin
                if (mem_rdy) state_n = ST_RD_HI;
            end
            ST_RD_HI: begin
                if (mem_rdy) begin
                    if (map_over_limit) begin
                        decide      = 1'b1;
                        decide_kind = DISP_FAULT;
                        state_n     = ST_DONE;
                    end else begin
                        state_n     = ST_RD_BM;
                    end
                end
            end
            ST_RD_BM: begin
                if (mem_rdy) begin
                    decide      = 1'b1;
                    decide_kind = map_bit ? DISP_PMODE : DISP_REAL;
                    state_n     = ST_DONE;
                end
            end
            ST_DONE:  state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            vec_q     <= '0;
            base_q    <= '0;
            limit_q   <= '0;
            map_ofs_q <= '0;
            ofs_lo_q  <= '0;
        end else begin
            state <= state_n;
            if (accept) begin
                vec_q   <= vector;
                base_q  <= tss_base;
                limit_q <= tss_limit;
            end
            if ((state == ST_RD_LO) && mem_rdy) ofs_lo_q <= mem_rdata;
            if ((state == ST_RD_HI) && mem_rdy) map_ofs_q <= map_ofs_next;
        end
    end

    assign mem_req = (state == ST_RD_LO) || (state == ST_RD_HI) || (state == ST_RD_BM);
    assign done    = (state == ST_DONE);

    // R9: completion lasts one cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: a map read is only issued inside the segment limit
    p_map_in_limit_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD_BM) |-> (map_ofs_q <= limit_q));

    // R4: high offset byte is only fetched after the low byte
    p_lo_before_hi_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD_HI) |-> ($past(state) == ST_RD_LO || $past(state) == ST_RD_HI));

endmodule

// File: rtl/v86rl_result.sv
module v86rl_result
    import v86rl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  disp_e  kind_in,
    output disp_t  res_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= make_disp(DISP_NONE);
        end else if (load) begin
            res_q <= make_disp(kind_in);
        end
    end

    // R7: real-mode style result carries the fixed table
    p_real_table_r7: assert property (@(posedge clk) disable iff (rst)
        (res_q.kind == DISP_REAL) |-> (res_q.base == '0 && res_q.limit == 16'h03FF && res_q.ar == 8'h92));

    // R8: every other result carries no table
    p_other_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (res_q.kind != DISP_REAL) |-> (res_q.base == '0 && res_q.limit == '0 && res_q.ar == '0));

endmodule

// File: rtl/v86_redirect_lookup.sv
module v86_redirect_lookup
    import v86rl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                ext_en,
    input  logic [VEC_W-1:0]    vector,
    input  logic [ADDR_W-1:0]   tss_base,
    input  logic [ADDR_W-1:0]   tss_limit,
    output logic                mem_req,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic                mem_rdy,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                done,
    output logic [1:0]          disp_kind,
    output logic [ADDR_W-1:0]   tbl_base,
    output logic [LIM_W-1:0]    tbl_limit,
    output logic [AR_W-1:0]     tbl_ar
);

    state_e              state;
    logic [VEC_W-1:0]    vec_q;
    logic [ADDR_W-1:0]   base_q;
    logic [ADDR_W-1:0]   limit_q;
    logic [ADDR_W-1:0]   map_ofs_q;
    logic [ADDR_W-1:0]   map_ofs_next;
    logic [DATA_W-1:0]   ofs_lo_q;
    logic                map_over_limit;
    logic                decide;
    disp_e               decide_kind;
    disp_t               res_q;

    v86rl_ctrl u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .start          (start),
        .ext_en         (ext_en),
        .vector         (vector),
        .tss_base       (tss_base),
        .tss_limit      (tss_limit),
        .mem_rdy        (mem_rdy),
        .mem_rdata      (mem_rdata),
        .map_ofs_next   (map_ofs_next),
        .map_over_limit (map_over_limit),
        .state          (state),
        .mem_req        (mem_req),
        .done           (done),
        .vec_q          (vec_q),
        .base_q         (base_q),
        .limit_q        (limit_q),
        .map_ofs_q      (map_ofs_q),
        .ofs_lo_q       (ofs_lo_q),
        .decide         (decide),
        .decide_kind    (decide_kind)
    );

    v86rl_addr_gen u_addr (
        .state          (state),
        .base_q         (base_q),
        .limit_q        (limit_q),
        .vec_q          (vec_q),
        .ofs_lo_q       (ofs_lo_q),
        .ofs_hi         (mem_rdata),
        .map_ofs_q      (map_ofs_q),
        .mem_addr       (mem_addr),
        .map_ofs_next   (map_ofs_next),
        .map_over_limit (map_over_limit)
    );

    v86rl_result u_res (
        .clk     (clk),
        .rst     (rst),
        .load    (decide),
        .kind_in (decide_kind),
        .res_q   (res_q)
    );

    assign disp_kind = res_q.kind;
    assign tbl_base  = res_q.base;
    assign tbl_limit = res_q.limit;
    assign tbl_ar    = res_q.ar;

    // Lookup class noted at acceptance, for the port-level checks below
    logic chk_ext_off;
    logic chk_small_lim;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_ext_off   <= 1'b0;
            chk_small_lim <= 1'b0;
        end else if ((state == ST_IDLE) && start) begin
            chk_ext_off   <= !ext_en;
            chk_small_lim <= ext_en && (tss_limit < MIN_TSS_LIMIT);
        end
    end

    // R4: a waiting request holds address
    p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr)));

    // R2: extensions off never touches memory and dispatches through the IDT
    p_ext_off_noreq_r2: assert property (@(posedge clk) disable iff (rst)
        chk_ext_off |-> !mem_req);
    p_ext_off_pmode_r2: assert property (@(posedge clk) disable iff (rst)
        (done && chk_ext_off) |-> (disp_kind == 2'd1));

    // R3: undersized segment faults without a read
    p_small_lim_noreq_r3: assert property (@(posedge clk) disable iff (rst)
        chk_small_lim |-> !mem_req);
    p_small_lim_fault_r3: assert property (@(posedge clk) disable iff (rst)
        (done && chk_small_lim) |-> (disp_kind == 2'd3));

    // R9: result held while idle without a start
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_IDLE) && !start) |=> ($stable(disp_kind) && $stable(tbl_base) && $stable(tbl_limit) && $stable(tbl_ar)));

endmodule

// File: tb/v86_redirect_lookup_tb_top.sv
module v86_redirect_lookup_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        ext_en;
    logic [7:0]  vector;
    logic [31:0] tss_base;
    logic [31:0] tss_limit;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rdy;
    logic [7:0]  mem_rdata;
    logic        done;
    logic [1:0]  disp_kind;
    logic [31:0] tbl_base;
    logic [15:0] tbl_limit;
    logic [7:0]  tbl_ar;

    logic [31:0] cur_base = 32'h0;
    logic [15:0] cur_ofs  = 16'h0;
    logic [7:0]  lfsr     = 8'h5B;
    int          hs_count = 0;
    logic [31:0] hs_addr [0:3];
    int          n_cmp = 0;
    int          n_bad = 0;
    int          cycles = 0;

    always #10 clk = ~clk;

    v86_redirect_lookup dut_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .ext_en    (ext_en),
        .vector    (vector),
        .tss_base  (tss_base),
        .tss_limit (tss_limit),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_rdy   (mem_rdy),
        .mem_rdata (mem_rdata),
        .done      (done),
        .disp_kind (disp_kind),
        .tbl_base  (tbl_base),
        .tbl_limit (tbl_limit),
        .tbl_ar    (tbl_ar)
    );

    // Memory image: offset field at base+102/103, a mixing pattern elsewhere
    function automatic logic [7:0] mem_byte(input logic [31:0] a, input logic [31:0] b,
                                            input logic [15:0] o);
        if (a == b + 32'd102) return o[7:0];
        if (a == b + 32'd103) return o[15:8];
        return a[7:0] ^ a[15:8] ^ {a[2:0], a[7:3]} ^ 8'hA5;
    endfunction

    always_comb mem_rdata = mem_byte(mem_addr, cur_base, cur_ofs);
    assign mem_rdy = mem_req && lfsr[0];

    // Ready pattern changes away from the active edge; handshakes recorded here
    always @(negedge clk) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (mem_req && lfsr[0]) begin
            if (hs_count < 4) hs_addr[hs_count] = mem_addr;
            hs_count++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_one(input logic [7:0] v, input logic e, input logic [31:0] b,
                           input logic [31:0] l, input logic [15:0] o);
        logic [31:0] bo;
        logic [7:0]  mb;
        logic [1:0]  ek;
        int          ehs;
        int          t;
        string       tag;
        bo  = {16'h0, o} - 32'd32 + {27'h0, v[7:3]};
        ehs = 0;
        if (!e) begin
            ek = 2'd1; tag = "R2";
        end else if (l < 32'd103) begin
            ek = 2'd3; tag = "R3";
        end else if (bo > l) begin
            ek = 2'd3; ehs = 2; tag = "R6";
        end else begin
            mb  = mem_byte(b + bo, b, o);
            ek  = mb[v[2:0]] ? 2'd1 : 2'd2;
            ehs = 3;
            tag = (ek == 2'd2) ? "R7" : "R8";
            if (b + bo == b + 32'd103) tag = "R10";
        end

        @(negedge clk);
        cur_base  = b;
        cur_ofs   = o;
        vector    = v;
        ext_en    = e;
        tss_base  = b;
        tss_limit = l;
        hs_count  = 0;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (!done && t < 200) begin
            @(negedge clk);
            t++;
        end
        chk("R9", "done seen", {31'h0, done}, 32'h1);
        chk(tag, "disp_kind", {30'h0, disp_kind}, {30'h0, ek});
        if (ek == 2'd2) begin
            chk("R7", "tbl_base", tbl_base, 32'h0);
            chk("R7", "tbl_limit", {16'h0, tbl_limit}, 32'h3FF);
            chk("R7", "tbl_ar", {24'h0, tbl_ar}, 32'h92);
        end else begin
            chk("R8", "table fields", {tbl_base | {16'h0, tbl_limit} | {24'h0, tbl_ar}}, 32'h0);
        end
        chk(tag, "read count", hs_count, ehs);
        if (ehs == 0) chk(tag, "done latency", t, 0);
        if (ehs >= 2) begin
            chk("R4", "low offset addr", hs_addr[0], b + 32'd102);
            chk("R4", "high offset addr", hs_addr[1], b + 32'd103);
        end
        if (ehs == 3) chk("R5", "map byte addr", hs_addr[2], b + bo);
        @(negedge clk);
        chk("R9", "done single cycle", {31'h0, done}, 32'h0);
        chk("R9", "result held", {30'h0, disp_kind}, {30'h0, ek});
    endtask

    task automatic sweep(input logic e, input logic [31:0] b, input logic [31:0] l,
                         input logic [15:0] o);
        for (int v = 0; v < 256; v++) run_one(8'(v), e, b, l, o);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; ext_en = 1'b0; vector = '0;
        tss_base = '0; tss_limit = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", "done", {31'h0, done}, 32'h0);
        chk("R1", "mem_req", {31'h0, mem_req}, 32'h0);
        chk("R1", "disp_kind", {30'h0, disp_kind}, 32'h0);
        chk("R1", "table fields", {tbl_base | {16'h0, tbl_limit} | {24'h0, tbl_ar}}, 32'h0);

        sweep(1'b0, 32'h0000_2000, 32'h0000_FFFF, 16'd200);   // R2
        sweep(1'b1, 32'h0000_3000, 32'd102,       16'd200);   // R3
        sweep(1'b1, 32'h0000_4000, 32'd103,       16'd135);   // R10 overlap, R6 boundary
        sweep(1'b1, 32'h0001_0000, 32'h0000_2000, 16'h0400);  // R5, R7, R8
        sweep(1'b1, 32'h0000_5000, 32'd178,       16'd200);   // R6 limit edge
        sweep(1'b1, 32'h0000_6000, 32'h0000_FFFF, 16'd16);    // R6 wrapped offset
        sweep(1'b1, 32'hFFFF_FFF0, 32'h0000_FFFF, 16'h0080);  // R5 address wrap

        // R9: start during a lookup is ignored
        begin
            logic [31:0] bo;
            logic [7:0]  mb;
            logic [1:0]  ek;
            int          t;
            bo = 32'h0400 - 32'd32 + 32'd2;
            mb = mem_byte(32'h0001_0000 + bo, 32'h0001_0000, 16'h0400);
            ek = mb[1] ? 2'd1 : 2'd2;
            @(negedge clk);
            cur_base = 32'h0001_0000; cur_ofs = 16'h0400;
            vector = 8'h11; ext_en = 1'b1; tss_base = 32'h0001_0000; tss_limit = 32'h2000;
            hs_count = 0; start = 1'b1;
            @(negedge clk);
            vector = 8'h12; ext_en = 1'b0;
            @(negedge clk);
            start = 1'b0;
            t = 0;
            while (!done && t < 200) begin
                @(negedge clk);
                t++;
            end
            chk("R9", "busy start kind", {30'h0, disp_kind}, {30'h0, ek});
            chk("R9", "busy start reads", hs_count, 3);
            chk("R9", "busy start map addr", hs_addr[2], 32'h0001_0000 + bo);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule